// File: doc/BRIEF.md
# Cascaded Two-Chip Interrupt Controller

This block joins two eight-input priority interrupt controllers into a sixteen-input system. Request lines 0 to 7 go to the master chip and lines 8 to 15 go to the slave chip. Whenever the slave has a request that beats its own in-service level, that request reaches the master on its input 2 as an edge event. The master drives the single CPU interrupt line.

Software configures both chips through a byte-wide I/O port. It uses a command port and a data port for each chip and one trigger-mode register for each chip. Each trigger-mode bit makes the matching request line level-triggered (1) or edge-triggered (0). When the CPU takes the interrupt, it pulses the acknowledge strobe for one clock. The block then marks the winning request in service on the master, and on the slave too when the cascade won. It also latches the 8-bit vector.

The register bus is a plain strobe interface with no back-pressure. A write strobe takes effect on the clock edge it is sampled on. Read data is combinational while the read strobe is high, and a read changes no state. Request line 2 has no effect, because master input 2 is reserved for the cascade.

Top module: `pic_cascade`

## Requirements
- R1: Only addresses 0x20, 0x21, 0xA0, 0xA1, 0x4D0 and 0x4D1 are decoded. Writes to any other address change nothing, and reads of them return 0.
- R2: A write to 0x4D0 stores the data ANDed with 0xF8 as the master trigger mode. A write to 0x4D1 stores the data ANDed with 0xDE as the slave trigger mode. Reads of either address return the stored value.
- R3: With its trigger-mode bit at 1, a request bit follows its line and is not cleared by acknowledge. With the bit at 0, the request is latched on a rising edge of the line and cleared when acknowledged.
- R4: Among unmasked requests, the lowest index wins by default. Writing a mask byte to a chip's data port (0x21/0xA1) outside initialisation blocks the set bits. Reading the data port returns the mask.
- R5: A command-port write with bit 4 set starts initialisation. Bit 0 of that write requests a fourth byte. The next data write sets the vector base with its low three bits dropped, the next one is taken and ignored, and the fourth byte follows only if it was requested.
- R6: A slave request reaches master input 2. On acknowledge, both chips mark it in service and the vector is the slave base plus the slave input index.
- R7: If the master has nothing to grant at acknowledge, the vector is the master base plus 7. If the master grants input 2 while the slave has nothing, the vector is the slave base plus 7.
- R8: An in-service bit blocks requests of equal or lower priority. Command 0x20 (non-specific end of interrupt) clears the highest-priority in-service bit.
- R9: Command 0x60|n clears in-service bit n. Command 0xE0|n clears it and makes n the lowest priority. Command 0xC0|n makes n the lowest priority.
- R10: Bit 1 of the fourth initialisation byte selects auto end-of-interrupt, which leaves no in-service bit after acknowledge.
- R11: Bit 4 of the fourth byte on the master selects nested mode for the cascade. In this mode, master in-service bit 2 is ignored when it is compared with a new request, so a higher slave request is granted.
- R12: The CPU interrupt line is registered. It reflects the master grant condition one clock after a request, mask, write or acknowledge changes it.
- R13: Command byte 0x0A selects the request register and 0x0B selects the in-service register for command-port reads. Starting initialisation reselects the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 16 | Request lines; 0-7 master, 8-15 slave; line 2 unused |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one clock per access |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational while io_rd is high |
| inta | input | 1 | Acknowledge strobe, one clock |
| intr | output | 1 | CPU interrupt request |
| vector | output | 8 | Vector latched on acknowledge |

## Verification
A table of trigger-mode and unmapped-address accesses separates the two writable-bit masks from each other and from ignored addresses. Directed sequences then drive patterns that each tell apart one pair of behaviours:
- two simultaneous edges, which separate priority order from blocking by an in-service bit;
- a held level line compared with an edge line, which separates the two trigger modes;
- a slave request that goes away before acknowledge, which separates the slave spurious vector from a real slave vector;
- slave requests nested under an in-service cascade, which separate nested mode from normal mode.

Rotation and the specific end-of-interrupt commands are checked by how the grant order changes afterwards.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NLINES = 8;
  localparam int IDX_W  = $clog2(NLINES);
  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] A_MCMD  = 16'h0020;
  localparam logic [ADDR_W-1:0] A_MDATA = 16'h0021;
  localparam logic [ADDR_W-1:0] A_SCMD  = 16'h00A0;
  localparam logic [ADDR_W-1:0] A_SDATA = 16'h00A1;
  localparam logic [ADDR_W-1:0] A_TMM   = 16'h04D0;
  localparam logic [ADDR_W-1:0] A_TMS   = 16'h04D1;

  localparam logic [NLINES-1:0] TM_MASK_MASTER = 8'hF8;
  localparam logic [NLINES-1:0] TM_MASK_SLAVE  = 8'hDE;
  localparam int CASCADE_IN = 2;
  localparam logic [IDX_W-1:0] SPURIOUS_IDX = 3'd7;

  typedef enum logic [1:0] {
    CFG_RUN,
    CFG_BASE,
    CFG_LINK,
    CFG_MODE
  } cfg_step_t;
endpackage

// File: rtl/pic_prio.sv
module pic_prio
  import pic_pkg::*;
(
  input  logic [NLINES-1:0] bits,
  input  logic [IDX_W-1:0]  rot,
  output logic              found,
  output logic [IDX_W-1:0]  level
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    found = 1'b0;
    level = '0;
    idx   = '0;
    for (int p = NLINES - 1; p >= 0; p--) begin
      idx = IDX_W'(p) + rot;
      if (bits[idx]) begin
        found = 1'b1;
        level = IDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter logic [NLINES-1:0] NEST_IGNORE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req,
  input  logic [NLINES-1:0] force_set,
  input  logic [NLINES-1:0] trig_level,
  input  logic              wr_cmd,
  input  logic              wr_data,
  input  logic [7:0]        wdata,
  input  logic              ack,
  output logic              win_valid,
  output logic [IDX_W-1:0]  win_idx,
  output logic [7:0]        base,
  output logic [7:0]        cmd_rdata,
  output logic [7:0]        data_rdata
);
  logic [NLINES-1:0] irr_q, isr_q, imr_q, last_q;
  logic [NLINES-1:0] irr_n, isr_n, imr_n, last_n;
  logic [IDX_W-1:0]  rot_q, rot_n;
  logic [7:0]        base_n;
  cfg_step_t         step_q, step_n;
  logic              want4_q, want4_n, nest_q, nest_n;
  logic              aeoi_q, aeoi_n, raeoi_q, raeoi_n, rsel_q, rsel_n;

  logic              req_found, isr_found, top_found;
  logic [IDX_W-1:0]  req_lvl, isr_lvl, top_lvl;
  logic [NLINES-1:0] isr_cmp;
  logic [IDX_W-1:0]  eoi_idx;

  assign isr_cmp = nest_q ? (isr_q & ~NEST_IGNORE) : isr_q;

  pic_prio u_req (.bits(irr_q & ~imr_q), .rot(rot_q), .found(req_found), .level(req_lvl));
  pic_prio u_isr (.bits(isr_cmp),        .rot(rot_q), .found(isr_found), .level(isr_lvl));
  pic_prio u_top (.bits(isr_q),          .rot(rot_q), .found(top_found), .level(top_lvl));

  assign win_valid  = req_found && (!isr_found || (req_lvl < isr_lvl));
  assign win_idx    = req_lvl + rot_q;
  assign eoi_idx    = top_lvl + rot_q;
  assign cmd_rdata  = rsel_q ? isr_q : irr_q;
  assign data_rdata = imr_q;

  always_comb begin
    irr_n   = (irr_q & ~trig_level) | (req & trig_level);
    irr_n   = irr_n | (req & ~last_q & ~trig_level) | force_set;
    last_n  = req;
    isr_n   = isr_q;
    imr_n   = imr_q;
    rot_n   = rot_q;
    base_n  = base;
    step_n  = step_q;
    want4_n = want4_q;
    nest_n  = nest_q;
    aeoi_n  = aeoi_q;
    raeoi_n = raeoi_q;
    rsel_n  = rsel_q;

    if (ack && win_valid) begin
      isr_n[win_idx] = 1'b1;
      if (!trig_level[win_idx]) irr_n[win_idx] = 1'b0;
      if (aeoi_q) begin
        if (raeoi_q) rot_n = win_idx + 1'b1;
        isr_n[win_idx] = 1'b0;
      end
    end

    if (wr_cmd) begin
      if (wdata[4]) begin
        want4_n = wdata[0];
        last_n  = '0;
        irr_n   = irr_q & trig_level;
        imr_n   = '0;
        rot_n   = '0;
        rsel_n  = 1'b0;
        if (!wdata[0]) begin
          nest_n = 1'b0;
          aeoi_n = 1'b0;
        end
        step_n = CFG_BASE;
      end else if (wdata[3]) begin
        if (wdata[1]) rsel_n = wdata[0];
      end else begin
        unique case (wdata[7:5])
          3'd0, 3'd4: raeoi_n = wdata[7];
          3'd1, 3'd5: begin
            if (top_found) begin
              if (wdata[7]) rot_n = eoi_idx + 1'b1;
              isr_n[eoi_idx] = 1'b0;
            end
          end
          3'd3: isr_n[wdata[IDX_W-1:0]] = 1'b0;
          3'd6: rot_n = wdata[IDX_W-1:0] + 1'b1;
          3'd7: begin
            rot_n = wdata[IDX_W-1:0] + 1'b1;
            isr_n[wdata[IDX_W-1:0]] = 1'b0;
          end
          default: ;
        endcase
      end
    end else if (wr_data) begin
      unique case (step_q)
        CFG_RUN:  imr_n = wdata;
        CFG_BASE: begin
          base_n = {wdata[7:IDX_W], {IDX_W{1'b0}}};
          step_n = CFG_LINK;
        end
        CFG_LINK: step_n = want4_q ? CFG_MODE : CFG_RUN;
        CFG_MODE: begin
          nest_n = wdata[4];
          aeoi_n = wdata[1];
          step_n = CFG_RUN;
        end
        default: step_n = CFG_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0; isr_q <= '0; imr_q <= '0; last_q <= '0;
      rot_q <= '0; base <= '0; step_q <= CFG_RUN;
      want4_q <= 1'b0; nest_q <= 1'b0; aeoi_q <= 1'b0;
      raeoi_q <= 1'b0; rsel_q <= 1'b0;
    end else begin
      irr_q <= irr_n; isr_q <= isr_n; imr_q <= imr_n; last_q <= last_n;
      rot_q <= rot_n; base <= base_n; step_q <= step_n;
      want4_q <= want4_n; nest_q <= nest_n; aeoi_q <= aeoi_n;
      raeoi_q <= raeoi_n; rsel_q <= rsel_n;
    end
  end
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*NLINES-1:0] irq_lines,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  input  logic              inta,
  output logic              intr,
  output logic [7:0]        vector
);
  localparam int NCHIP = 2;

  logic             chip_sel, port_sel, hit_pic, hit_tm;
  logic [NLINES-1:0] tm_q [NCHIP];
  logic [NLINES-1:0] req_c [NCHIP];
  logic [NLINES-1:0] force_c [NCHIP];
  logic             valid_c [NCHIP];
  logic [IDX_W-1:0] idx_c [NCHIP];
  logic [7:0]       base_c [NCHIP];
  logic [7:0]       cmdrd_c [NCHIP];
  logic [7:0]       datrd_c [NCHIP];
  logic             ack_c [NCHIP];
  logic             m_valid, s_valid, cas_win;
  logic [IDX_W-1:0] m_idx, s_idx;

  assign hit_pic = (io_addr == A_MCMD) || (io_addr == A_MDATA) ||
                   (io_addr == A_SCMD) || (io_addr == A_SDATA);
  assign hit_tm  = (io_addr == A_TMM) || (io_addr == A_TMS);
  assign chip_sel = hit_tm ? io_addr[0] : io_addr[7];
  assign port_sel = io_addr[0];

  assign m_valid = valid_c[0];
  assign s_valid = valid_c[1];
  assign m_idx   = idx_c[0];
  assign s_idx   = idx_c[1];
  assign cas_win = m_valid && (m_idx == IDX_W'(CASCADE_IN));

  always_comb begin
    req_c[0]  = irq_lines[NLINES-1:0];
    req_c[0][CASCADE_IN] = 1'b0;
    req_c[1]  = irq_lines[2*NLINES-1:NLINES];
    force_c[0] = '0;
    force_c[0][CASCADE_IN] = s_valid;
    force_c[1] = '0;
    ack_c[0] = inta;
    ack_c[1] = inta && cas_win;
  end

  for (genvar g = 0; g < NCHIP; g++) begin : g_chip
    localparam logic [NLINES-1:0] IGN  = (g == 0) ? (8'h01 << CASCADE_IN) : 8'h00;
    localparam logic [NLINES-1:0] TMSK = (g == 0) ? TM_MASK_MASTER : TM_MASK_SLAVE;
    logic sel_here;
    assign sel_here = (chip_sel == g[0]);

    pic_core #(.NEST_IGNORE(IGN)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req_c[g]),
      .force_set  (force_c[g]),
      .trig_level (tm_q[g]),
      .wr_cmd     (io_wr && hit_pic && sel_here && !port_sel),
      .wr_data    (io_wr && hit_pic && sel_here && port_sel),
      .wdata      (io_wdata),
      .ack        (ack_c[g]),
      .win_valid  (valid_c[g]),
      .win_idx    (idx_c[g]),
      .base       (base_c[g]),
      .cmd_rdata  (cmdrd_c[g]),
      .data_rdata (datrd_c[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        tm_q[g] <= '0;
      else if (io_wr && hit_tm && sel_here) tm_q[g] <= io_wdata & TMSK;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (hit_tm)        io_rdata = tm_q[chip_sel];
      else if (hit_pic)  io_rdata = port_sel ? datrd_c[chip_sel] : cmdrd_c[chip_sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr   <= 1'b0;
      vector <= '0;
    end else begin
      intr <= m_valid;
      if (inta) begin
        if (!m_valid)     vector <= base_c[0] + 8'(SPURIOUS_IDX);
        else if (cas_win) vector <= base_c[1] + 8'(s_valid ? s_idx : SPURIOUS_IDX);
        else              vector <= base_c[0] + 8'(m_idx);
      end
    end
  end
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk
  import pic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic              inta,
  input logic              intr,
  input logic [7:0]        vector,
  input logic              m_valid,
  input logic [IDX_W-1:0]  m_idx,
  input logic              s_valid,
  input logic [IDX_W-1:0]  s_idx
);
  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr[15:11] != 5'd0) |-> io_rdata == 8'h00);

  p_tm_master_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == A_TMM) |-> io_rdata[2:0] == 3'b000);

  p_tm_slave_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == A_TMS) |-> (io_rdata & 8'h21) == 8'h00);

  p_intr_tracks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> intr == $past(m_valid));

  p_spurious_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !m_valid) |=> vector[2:0] == SPURIOUS_IDX);

  p_slave_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && m_valid && m_idx == IDX_W'(CASCADE_IN) && s_valid) |=> vector[2:0] == $past(s_idx));
endmodule

bind pic_cascade pic_cascade_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_rdata(io_rdata),
  .inta(inta), .intr(intr), .vector(vector), .m_valid(m_valid), .m_idx(m_idx),
  .s_valid(s_valid), .s_idx(s_idx)
);

// File: tb/pic_cascade_tb.sv
module pic_cascade_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0, inta = 1'b0;
  logic [7:0]  io_rdata, vector;
  logic        intr;
  int          n_run = 0, n_fail = 0;
  logic [7:0]  v;

  always #5 clk = ~clk;

  pic_cascade dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .inta(inta), .intr(intr), .vector(vector)
  );

  // addr, write data, expected read-back
  localparam int NV = 7;
  localparam logic [31:0] VEC [NV] = '{
    {16'h04D0, 8'hFF, 8'hF8},
    {16'h04D1, 8'hFF, 8'hDE},
    {16'h04D0, 8'h21, 8'h20},
    {16'h04D1, 8'h01, 8'h00},
    {16'h0123, 8'h55, 8'h00},
    {16'h04D0, 8'h00, 8'h00},
    {16'h04D1, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic ack(output logic [7:0] d);
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    d = vector;
  endtask

  task automatic line(input int n, input logic val);
    @(negedge clk);
    irq_lines[n] = val;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R12 reset intr", {7'd0, intr}, 8'h00);
    chk("R12 reset vector", vector, 8'h00);
    rd(16'h0021, v); chk("R4 reset mask", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][31:16], VEC[i][15:8]);
      rd(VEC[i][31:16], v);
      chk((VEC[i][31:16] == 16'h0123) ? "R1 unmapped" : "R2 trigger mask", v, VEC[i][7:0]);
    end

    // R5 initialisation of both chips
    wr(16'h0020, 8'h11); wr(16'h0021, 8'h23); wr(16'h0021, 8'h04); wr(16'h0021, 8'h01);
    wr(16'h00A0, 8'h11); wr(16'h00A1, 8'h28); wr(16'h00A1, 8'h02); wr(16'h00A1, 8'h01);

    // R1: unmapped write leaves mask intact
    wr(16'h0022, 8'hFF);
    rd(16'h0021, v); chk("R1 ignored write", v, 8'h00);

    // R12 timing and R4 priority, R8 blocking
    @(negedge clk); irq_lines[3] = 1'b1; irq_lines[5] = 1'b1;
    tick(1); chk("R12 intr not yet", {7'd0, intr}, 8'h00);
    tick(1); chk("R12 intr raised", {7'd0, intr}, 8'h01);
    ack(v); chk("R5 R4 base plus irq3", v, 8'h23);
    wr(16'h0020, 8'h0B);
    rd(16'h0020, v); chk("R13 in-service read", v, 8'h08);
    wr(16'h0020, 8'h0A);
    rd(16'h0020, v); chk("R3 edge cleared on ack", v, 8'h20);
    tick(1); chk("R8 intr blocked", {7'd0, intr}, 8'h00);
    ack(v); chk("R7 master spurious", v, 8'h27);
    wr(16'h0020, 8'h20);
    tick(2); ack(v); chk("R8 after eoi", v, 8'h25);
    wr(16'h0020, 8'h20);
    line(3, 1'b0); line(5, 1'b0);

    // R4 mask
    wr(16'h0021, 8'h08);
    rd(16'h0021, v); chk("R4 mask read", v, 8'h08);
    line(3, 1'b1); tick(3);
    chk("R4 masked no intr", {7'd0, intr}, 8'h00);
    wr(16'h0021, 8'h00); tick(1);
    chk("R4 unmask intr", {7'd0, intr}, 8'h01);
    ack(v); chk("R4 vector", v, 8'h23);
    wr(16'h0020, 8'h20); line(3, 1'b0);

    // R3 level mode
    wr(16'h04D0, 8'h20);
    line(5, 1'b1); tick(3);
    ack(v); chk("R3 level vector", v, 8'h25);
    rd(16'h0020, v); chk("R3 level kept", v, 8'h20);
    wr(16'h0020, 8'h20); line(5, 1'b0); tick(2);
    rd(16'h0020, v); chk("R3 level follows line", v, 8'h00);
    wr(16'h04D0, 8'h00);

    // R6 cascade
    line(12, 1'b1); tick(4);
    chk("R6 intr via cascade", {7'd0, intr}, 8'h01);
    ack(v); chk("R6 slave vector", v, 8'h2C);
    wr(16'h0020, 8'h0B); wr(16'h00A0, 8'h0B);
    rd(16'h0020, v); chk("R6 master isr2", v, 8'h04);
    rd(16'h00A0, v); chk("R6 slave isr4", v, 8'h10);
    wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20); line(12, 1'b0);

    // R7 slave spurious
    wr(16'h04D1, 8'h02);
    line(9, 1'b1); tick(4); line(9, 1'b0); tick(3);
    ack(v); chk("R7 slave spurious", v, 8'h2F);
    wr(16'h0020, 8'h20); wr(16'h04D1, 8'h00);

    // R9 specific eoi and rotation
    @(negedge clk); irq_lines[4] = 1'b1; irq_lines[6] = 1'b1;
    tick(3); ack(v); chk("R9 first", v, 8'h24);
    wr(16'h0020, 8'h64); tick(2);
    ack(v); chk("R9 after specific eoi", v, 8'h26);
    wr(16'h0020, 8'hE6);
    @(negedge clk); irq_lines[4] = 1'b0; irq_lines[6] = 1'b0;
    @(negedge clk); irq_lines[1] = 1'b1; irq_lines[7] = 1'b1;
    tick(3); ack(v); chk("R9 rotated priority", v, 8'h27);
    wr(16'h0020, 8'h20); tick(2);
    ack(v); chk("R9 next after rotate", v, 8'h21);
    wr(16'h0020, 8'h20); wr(16'h0020, 8'hC7);
    @(negedge clk); irq_lines[1] = 1'b0; irq_lines[7] = 1'b0;

    // R10 auto eoi
    wr(16'h0020, 8'h11); wr(16'h0021, 8'h20); wr(16'h0021, 8'h04); wr(16'h0021, 8'h03);
    line(6, 1'b1); tick(3);
    ack(v); chk("R10 vector", v, 8'h26);
    wr(16'h0020, 8'h0B);
    rd(16'h0020, v); chk("R10 no in-service", v, 8'h00);
    line(6, 1'b0);

    // R11 nested mode on master
    wr(16'h0020, 8'h11); wr(16'h0021, 8'h20); wr(16'h0021, 8'h04); wr(16'h0021, 8'h11);
    line(13, 1'b1); tick(4);
    ack(v); chk("R11 first slave", v, 8'h2D);
    line(11, 1'b1); tick(4);
    chk("R11 intr nested", {7'd0, intr}, 8'h01);
    ack(v); chk("R11 nested slave", v, 8'h2B);
    wr(16'h00A0, 8'h20); wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20);
    line(11, 1'b0); line(13, 1'b0);
    tick(3);
    chk("R12 idle intr", {7'd0, intr}, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule